// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block runs the digital timing of one successive-approximation conversion, with optional averaging in hardware. A start pulse latches an 8-bit configuration word. That word selects the result resolution, a long-sample adder L and an averaging count N. The block then counts a fixed setup interval of 6 clocks. After that it runs N back-to-back phases. Each phase lasts the base time of 25 clocks plus L.

In the last cycle of every phase the block raises a one-cycle sample request. The external converter must present its raw 12-bit code on `raw_in` in that cycle. The block adds the N codes, divides by N with round-to-nearest and masks the average to the selected resolution. It presents the average on `result` with a one-cycle `done` pulse. The whole conversion therefore takes 6 + N × (25 + L) clocks.

Configuration word layout: bits [1:0] resolution code, bit [2] long-sample enable, bits [4:3] sample-time code, bit [5] averaging enable, bits [7:6] averaging select.

Top module: `adc_avg_sequencer`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `smp_req` and `busy` are 0 and `result` is 0.
- R2: If `start` is high at the clock edge E0 while the block is idle, `done` rises at edge E0+T, where T = 6 + N × (25 + L). `busy` is high from E0 until that edge.
- R3: L is selected by bit [2] and bits [4:3] of the configuration word. With bit [2] = 0, codes 0, 1, 2 and 3 give 3, 5, 7 and 9 clocks. With bit [2] = 1, the same codes give 13, 17, 21 and 25 clocks.
- R4: N is selected by bits [7:6] and bit [5] of the configuration word. With bit [5] = 0, N is 1. With bit [5] = 1, select codes 0, 1, 2 and 3 give N = 4, 8, 16 and 32.
- R5: Each conversion raises `smp_req` exactly N times. Each request lasts one cycle and falls in the last cycle of a phase. `raw_in` is taken at the edge that ends the request cycle.
- R6: `result` is floor((sum + N/2) / N) of the N captured codes, i.e. the average rounded to nearest with halves rounded up.
- R7: Bits [1:0] of the configuration word select the resolution: code 0 keeps result bits [7:0], code 1 keeps [9:0], codes 2 and 3 keep [11:0]. All higher result bits are 0.
- R8: A `start` pulse while `busy` is high is ignored. The running conversion keeps its timing and result, and no extra `done` follows.
- R9: `done` is high for exactly one cycle. `result` changes only at the edge where `done` rises and holds until the next such edge.
- R10: The configuration word is taken only at the accepted start edge. Changes to it during a conversion have no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only while idle |
| cfg_word | input | 8 | Resolution, long-sample and averaging selection |
| raw_in | input | 12 | Raw code from the converter, valid in a request cycle |
| smp_req | output | 1 | One-cycle request for a raw sample |
| busy | output | 1 | High while a conversion runs |
| done | output | 1 | One-cycle pulse when `result` is new |
| result | output | 12 | Averaged, resolution-masked conversion result |

## Verification
The assertions take for granted that `raw_in` carries a settled code throughout every cycle in which `smp_req` is high. They also assume that `rst` is asserted from time zero for at least one edge. The stub converter in the bench meets the first assumption by loading the next code at the falling edge inside each request cycle, so the code is stable before the capturing edge. The bench holds reset high from the start to meet the second. Starts are driven away from the clock edge. The bench deliberately offers `start` pulses and configuration changes during busy periods, because those are legal inputs the design must ignore.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // configuration word, most significant field first
  typedef struct packed {
    logic [1:0] avg_sel;   // [7:6]
    logic       avg_en;    // [5]
    logic [1:0] st_code;   // [4:3]
    logic       long_en;   // [2]
    logic [1:0] res_code;  // [1:0]
  } adc_cfg_t;

  localparam int CFG_W = $bits(adc_cfg_t);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_PHASE = 2'd2
  } seq_state_e;

  localparam logic [1:0] RES_CODE_8  = 2'd0;
  localparam logic [1:0] RES_CODE_10 = 2'd1;

endpackage

// File: rtl/adcseq_decode.sv
module adcseq_decode
  import adcseq_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int ADD_W  = 5,
  parameter int LOGN_W = 3
) (
  input  adc_cfg_t          cfg_i,
  output logic [ADD_W-1:0]  adder_o,
  output logic [LOGN_W-1:0] avg_log2_o,
  output logic [RAW_W-1:0]  mask_o
);

  logic [ADD_W-1:0] code_ext;
  int               keep_bits;

  always_comb begin
    code_ext = ADD_W'(cfg_i.st_code);
    // short adders step by 2 from 3, long adders step by 4 from 13
    if (cfg_i.long_en) adder_o = ADD_W'(13) + (code_ext << 2);
    else               adder_o = ADD_W'(3)  + (code_ext << 1);

    // averaging counts are powers of two: 4 << sel
    if (cfg_i.avg_en) avg_log2_o = LOGN_W'(cfg_i.avg_sel) + LOGN_W'(2);
    else              avg_log2_o = '0;

    case (cfg_i.res_code)
      RES_CODE_8:  keep_bits = 8;
      RES_CODE_10: keep_bits = 10;
      default:     keep_bits = RAW_W;
    endcase
    for (int i = 0; i < RAW_W; i++) mask_o[i] = (i < keep_bits);
  end

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer
  import adcseq_pkg::*;
#(
  parameter int SETUP_CYC = 6,
  parameter int BASE_CYC  = 25,
  parameter int ADD_W     = 5,
  parameter int LOGN_W    = 3,
  parameter int MAX_LOG2  = 5,
  localparam int CNT_W    = $clog2(BASE_CYC + SETUP_CYC + (1 << ADD_W)),
  localparam int PH_W     = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADD_W-1:0]  adder_i,
  input  logic [LOGN_W-1:0] avg_log2_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              last_o
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  left_q;
  logic             req_q;
  logic             last_q;
  logic [CNT_W-1:0] phase_len_m1;
  logic [PH_W-1:0]  phases_m1;
  logic             req_next;

  assign phase_len_m1 = CNT_W'(BASE_CYC) + CNT_W'(adder_i) - CNT_W'(1);
  assign phases_m1    = (PH_W'(1) << avg_log2_i) - PH_W'(1);
  assign req_next     = (state_q == SEQ_PHASE) && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      req_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      req_q  <= req_next;
      last_q <= req_next && (left_q == '0);
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_SETUP;
            cnt_q   <= CNT_W'(SETUP_CYC - 1);
          end
        end
        SEQ_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_PHASE;
            cnt_q   <= phase_len_m1;
            left_q  <= phases_m1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        SEQ_PHASE: begin
          if (cnt_q == '0) begin
            if (left_q == '0) begin
              state_q <= SEQ_IDLE;
            end else begin
              left_q <= left_q - PH_W'(1);
              cnt_q  <= phase_len_m1;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);
  assign req_o  = req_q;
  assign last_o = last_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);  // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q != SEQ_IDLE) |=> !(state_q == SEQ_SETUP && cnt_q == CNT_W'(SETUP_CYC - 1)));  // R8

  AST_PHASES_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_PHASE) |-> (left_q <= phases_m1));  // R4

endmodule

// File: rtl/adcseq_accum.sv
module adcseq_accum #(
  parameter int RAW_W    = 12,
  parameter int LOGN_W   = 3,
  parameter int MAX_LOG2 = 5,
  localparam int SUM_W   = RAW_W + MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              req_i,
  input  logic              last_i,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [LOGN_W-1:0] avg_log2_i,
  input  logic [RAW_W-1:0]  mask_i,
  output logic [RAW_W-1:0]  result_o,
  output logic              done_o
);

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] sum_next;
  logic [SUM_W-1:0] half;
  logic [SUM_W-1:0] rounded;
  logic [RAW_W-1:0] result_q;
  logic             done_q;

  always_comb begin
    sum_next = acc_q + SUM_W'(raw_i);
    half     = (SUM_W'(1) << avg_log2_i) >> 1;
    rounded  = (sum_next + half) >> avg_log2_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clear_i)    acc_q <= '0;
      else if (req_i) acc_q <= sum_next;
      if (req_i && last_i) begin
        result_q <= RAW_W'(rounded) & mask_i;
        done_q   <= 1'b1;
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);  // R9

  AST_RESULT_MASKED: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ((result_q & ~mask_i) == '0));  // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_q) |-> done_q);  // R9

  AST_AVG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_i && last_i) |-> (rounded[SUM_W-1:RAW_W] == '0));  // R6

endmodule

// File: rtl/adc_avg_sequencer.sv
module adc_avg_sequencer
  import adcseq_pkg::*;
#(
  parameter int SETUP_CYC = 6,
  parameter int BASE_CYC  = 25,
  parameter int RAW_W     = 12,
  parameter int MAX_LOG2  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       cfg_word,
  input  logic [RAW_W-1:0] raw_in,
  output logic             smp_req,
  output logic             busy,
  output logic             done,
  output logic [RAW_W-1:0] result
);

  localparam int ADD_W  = 5;
  localparam int LOGN_W = $clog2(MAX_LOG2 + 1);

  adc_cfg_t          cfg_q;
  logic              start_acc;
  logic [ADD_W-1:0]  adder;
  logic [LOGN_W-1:0] avg_log2;
  logic [RAW_W-1:0]  res_mask;
  logic              last_req;

  assign start_acc = start && !busy;

  always_ff @(posedge clk) begin
    if (rst)            cfg_q <= '0;
    else if (start_acc) cfg_q <= adc_cfg_t'(cfg_word);
  end

  adcseq_decode #(
    .RAW_W (RAW_W),
    .ADD_W (ADD_W),
    .LOGN_W(LOGN_W)
  ) u_decode (
    .cfg_i     (cfg_q),
    .adder_o   (adder),
    .avg_log2_o(avg_log2),
    .mask_o    (res_mask)
  );

  adcseq_timer #(
    .SETUP_CYC(SETUP_CYC),
    .BASE_CYC (BASE_CYC),
    .ADD_W    (ADD_W),
    .LOGN_W   (LOGN_W),
    .MAX_LOG2 (MAX_LOG2)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_acc),
    .adder_i   (adder),
    .avg_log2_i(avg_log2),
    .busy_o    (busy),
    .req_o     (smp_req),
    .last_o    (last_req)
  );

  adcseq_accum #(
    .RAW_W   (RAW_W),
    .LOGN_W  (LOGN_W),
    .MAX_LOG2(MAX_LOG2)
  ) u_accum (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (start_acc),
    .req_i     (smp_req),
    .last_i    (last_req),
    .raw_i     (raw_in),
    .avg_log2_i(avg_log2),
    .mask_i    (res_mask),
    .result_o  (result),
    .done_o    (done)
  );

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_q));  // R10

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    smp_req |-> busy);  // R5

endmodule

// File: tb/test_adc_avg_sequencer.sv
module test_adc_avg_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  cfg_word = 8'h00;
  logic [11:0] raw_in = 12'h000;
  logic        smp_req;
  logic        busy;
  logic        done;
  logic [11:0] result;

  always #5 clk = ~clk;

  adc_avg_sequencer i_adc_avg_sequencer (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cfg_word(cfg_word),
    .raw_in  (raw_in),
    .smp_req (smp_req),
    .busy    (busy),
    .done    (done),
    .result  (result)
  );

  typedef struct {
    int    exp_cycles;
    int    exp_result;
    int    exp_reqs;
    int    start_cyc;
    string tag;
  } item_t;

  item_t sb[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  int    raw_vals[32];
  int    raw_idx  = 0;
  int    req_seen = 0;
  int    n_done   = 0;
  bit    prev_done = 1'b0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int lsa_of(input logic [7:0] c);
    int tbl[8] = '{3, 5, 7, 9, 13, 17, 21, 25};
    return tbl[{c[2], c[4:3]}];
  endfunction

  function automatic int navg_of(input logic [7:0] c);
    return c[5] ? (4 << c[7:6]) : 1;
  endfunction

  function automatic int mask_of(input logic [7:0] c);
    return (c[1:0] == 2'd0) ? 255 : (c[1:0] == 2'd1) ? 1023 : 4095;
  endfunction

  task automatic launch(input logic [7:0] c, input string tag);
    item_t it;
    int n, sum;
    n = navg_of(c);
    sum = 0;
    for (int k = 0; k < n; k++) sum += raw_vals[k];
    it.exp_cycles = 6 + n * (25 + lsa_of(c));
    it.exp_result = ((sum + n / 2) / n) & mask_of(c);
    it.exp_reqs   = n;
    it.tag        = tag;
    @(negedge clk);
    cfg_word = c;
    start    = 1'b1;
    raw_idx  = 0;
    req_seen = 0;
    it.start_cyc = cyc;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  // cycle counter
  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // stub converter: code presented inside the request cycle
  initial forever begin
    @(negedge clk);
    if (smp_req) begin
      raw_in = 12'(raw_vals[raw_idx % 32]);
      raw_idx++;
      req_seen++;
    end
  end

  // monitor / scoreboard
  initial forever begin
    item_t it;
    int meas;
    @(negedge clk);
    if (prev_done) check(!done, "R9 done width", int'(done), 0);
    prev_done = done;
    if (!rst && done) begin
      n_done++;
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        it = sb.pop_front();
        meas = cyc - it.start_cyc - 1;
        check(meas == it.exp_cycles, {"R2 cycles ", it.tag}, meas, it.exp_cycles);
        check(int'(result) == it.exp_result, {"R6 result ", it.tag}, int'(result), it.exp_result);
        check(req_seen == it.exp_reqs, {"R5 requests ", it.tag}, req_seen, it.exp_reqs);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 200000);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] c;
    int run, held, done_before;
    for (int k = 0; k < 32; k++) raw_vals[k] = 0;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(!done && !smp_req && !busy, "R1 outputs in reset", int'({done, smp_req, busy}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!done && !smp_req && !busy, "R1 outputs after reset", int'({done, smp_req, busy}), 0);
    check(result == 12'd0, "R1 result after reset", int'(result), 0);

    // R2/R3/R4: every long-sample adder with every averaging count
    run = 0;
    for (int lg = 0; lg < 2; lg++)
      for (int st = 0; st < 4; st++)
        for (int av = 0; av < 5; av++) begin
          c = {(av == 0) ? 2'b00 : 2'(av - 1), (av != 0), 2'(st), 1'(lg), 2'b10};
          for (int k = 0; k < 32; k++) raw_vals[k] = (run * 131 + k * 577 + 19) % 4096;
          launch(c, $sformatf("R3 R4 L=%0d N=%0d", lsa_of(c), navg_of(c)));
          wait_idle();
          run++;
        end

    // R7: resolution masks with full-scale codes
    for (int k = 0; k < 32; k++) raw_vals[k] = 4095;
    launch(8'b000_00_0_00, "R7 8-bit");
    wait_idle();
    launch(8'b000_00_0_01, "R7 10-bit");
    wait_idle();
    launch(8'b000_00_0_11, "R7 code3 12-bit");
    wait_idle();
    launch(8'b111_11_1_10, "R7 R6 full scale N=32");
    wait_idle();
    // 8-bit mask applied after averaging
    for (int k = 0; k < 32; k++) raw_vals[k] = 300 + k;
    launch(8'b001_01_0_00, "R7 8-bit N=4");
    wait_idle();

    // R6: rounding at half-way points
    for (int k = 0; k < 32; k++) raw_vals[k] = 0;
    raw_vals[3] = 2;
    launch(8'b001_00_0_10, "R6 N=4 half up");
    wait_idle();
    raw_vals[3] = 0; raw_vals[0] = 1;
    launch(8'b001_00_0_10, "R6 N=4 below half");
    wait_idle();
    raw_vals[0] = 12;
    launch(8'b011_00_0_10, "R6 N=8 sum12");
    wait_idle();
    raw_vals[0] = 11;
    launch(8'b011_00_0_10, "R6 N=8 sum11");
    wait_idle();

    // R9: result holds after done
    held = int'(result);
    repeat (20) @(negedge clk);
    check(int'(result) == held, "R9 result hold", int'(result), held);

    // R8: start during a conversion is ignored
    for (int k = 0; k < 32; k++) raw_vals[k] = 1000 + 7 * k;
    done_before = n_done;
    launch(8'b011_10_1_10, "R8 first conversion");
    repeat (20) @(negedge clk);
    cfg_word = 8'b000_00_0_00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8 still busy", int'(busy), 1);
    wait_idle();
    repeat (120) @(negedge clk);
    check(n_done - done_before == 1, "R8 done count", n_done - done_before, 1);

    // R10: configuration changes during a conversion have no effect
    for (int k = 0; k < 32; k++) raw_vals[k] = 2000 + 13 * k;
    launch(8'b001_01_0_10, "R10 cfg latched");
    repeat (3) @(negedge clk);
    cfg_word = 8'b111_11_1_00;
    wait_idle();

    // back-to-back start right after done
    launch(8'b000_00_0_10, "R2 back-to-back A");
    while (!done) @(negedge clk);
    launch(8'b000_11_1_10, "R2 back-to-back B");
    wait_idle();

    check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
    summary();
    $finish;
  end

endmodule